// File: doc/BRIEF.md
# Metering Tone Burst Generator

This block produces a line-metering (billing pulse) tone and adds it into a stream of receive-path audio samples. A phase accumulator drives a quarter-wave sine lookup at either 12 kHz or 16 kHz. The resulting sine is scaled by an amplitude envelope. The envelope moves linearly toward a programmable peak level while metering is requested, and linearly back to zero when it is released. A fast-ramp control shortens the envelope transition from about 20 ms to about 4 ms.

All state advances once per audio sample, marked by a one-cycle sample strobe. On each strobe the block registers two outputs: the scaled tone sample on its own, and the saturated sum of that tone and the incoming audio sample. Both outputs are computed from the phase and envelope held before that strobe. The phase and envelope then advance for the next sample. Everything downstream of the sample sum (conversion, line drive) is outside this block.

Top module: `mtr_burst_gen`

## Requirements
- R1: The 16-bit phase accumulator advances on each strobe by round(F·65536/48000). With `tone_sel`=0 this is 16384 (12 kHz); with `tone_sel`=1 it is 21845 (16 kHz). Changing `tone_sel` alters only the increment, and the phase carries on from its current value.
- R2: The sine value for a phase p uses the quadrant q=p[15:14] and the address a=p[13:8]. The index is i=64−a when q is odd, and i=a otherwise. The magnitude is floor(32767·sin(π·i/128)+0.5). The value is negated when q≥2.
- R3: With `fast_ramp`=0, the 16-bit envelope (code·256, so 8 fractional bits) changes by at most 68 per strobe. From zero it reaches the full-scale target 65280 after 960 strobes (20 ms).
- R4: While `meter_on`=1 the envelope target is `level_code`·256. Each code step stands for 4 mV of peak level, so codes 0 to 255 cover 0 to 1020 mV. The envelope never exceeds 65280.
- R5: With `fast_ramp`=1 the step is 340 per strobe, so full scale is reached from zero in 192 strobes (4 ms).
- R6: With `meter_on`=0 the target is 0. The envelope falls to 0 at the selected step and then stays there.
- R7: When the target changes during a ramp, the envelope moves from its present value toward the new target by at most one step per strobe. It lands exactly on the target when the remaining gap is no larger than a step.
- R8: On each strobe, `tone_out` is loaded with sine·envelope/65536, truncated toward zero. The sine and envelope used are the ones held before that strobe.
- R9: On each strobe, `audio_out` is loaded with `audio_in` + tone, clamped to the range −32768 to 32767 instead of wrapping.
- R10: While reset is low and just after it, both outputs, the phase and the envelope are zero.
- R11: Without a strobe, the outputs and the envelope keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe per audio sample |
| tone_sel | input | 1 | 0 selects 12 kHz, 1 selects 16 kHz |
| level_code | input | 8 | Target peak level, 4 mV per code |
| meter_on | input | 1 | 1 requests metering, 0 returns to the plain active state |
| fast_ramp | input | 1 | 1 selects the short envelope ramp |
| audio_in | input | 16 | Signed receive-path audio sample |
| tone_out | output | 16 | Signed scaled tone sample |
| audio_out | output | 16 | Signed saturated sum of audio and tone |

## Verification
Two things can fall on the same strobe: a positive tone peak at full envelope, and an audio sample near the positive or negative limit. When they coincide, the clamp must act on exactly the sample the envelope has just raised. The bench provokes this by holding the 12 kHz tone at full level while feeding audio at ±32000, and judges each sample against an arithmetic model of the sum and clamp. A second collision happens when the target is lowered or raised within one step of the current envelope. The bench provokes it by moving `level_code` during a ramp and checks that the tone amplitude lands on the new level without jumping past it.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

   typedef enum logic {
      TONE_LOW  = 1'b0,
      TONE_HIGH = 1'b1
   } tone_e;

   // Phase increment per sample, rounded to nearest.
   function automatic int phase_inc(input int f_hz, input int fs_hz, input int pw);
      longint num;
      num = (longint'(f_hz) << pw) + longint'(fs_hz / 2);
      return int'(num / longint'(fs_hz));
   endfunction

   // One entry of the quarter-wave magnitude table.
   function automatic int quarter_sine(input int idx, input int qbits, input int amp);
      real ang;
      real val;
      ang = 3.14159265358979323846 * real'(idx) / (2.0 * real'(1 << qbits));
      val = $sin(ang) * real'(amp);
      return int'($floor(val + 0.5));
   endfunction

   // Ramp step that reaches full scale within n samples.
   function automatic int ramp_step(input int full, input int n);
      return (full + n - 1) / n;
   endfunction

endpackage

// File: rtl/mtr_phase_acc.sv
module mtr_phase_acc #(
   parameter int PH_W   = 16,
   parameter int INC_LO = 16384,
   parameter int INC_HI = 21845
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic            sel,
   output logic [PH_W-1:0] phase
);
   localparam logic [PH_W-1:0] STEP_LO = PH_W'(INC_LO);
   localparam logic [PH_W-1:0] STEP_HI = PH_W'(INC_HI);

   mtr_pkg::tone_e  tone;
   logic [PH_W-1:0] inc;

   always_comb begin
      tone = mtr_pkg::tone_e'(sel);
      case (tone)
         mtr_pkg::TONE_HIGH: inc = STEP_HI;
         default:            inc = STEP_LO;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   phase <= '0;
      else if (adv) phase <= phase + inc;
   end
endmodule

// File: rtl/mtr_sine_lut.sv
module mtr_sine_lut #(
   parameter int LUT_AW = 6,
   parameter int SMP_W  = 16
) (
   input  logic [LUT_AW+1:0]       ph_top,
   output logic signed [SMP_W-1:0] sine
);
   localparam int NQ  = 1 << LUT_AW;
   localparam int AMP = (1 << (SMP_W - 1)) - 1;

   logic [SMP_W-2:0] tbl [0:NQ];

   for (genvar gi = 0; gi <= NQ; gi++) begin : g_tbl
      localparam int VAL = mtr_pkg::quarter_sine(gi, LUT_AW, AMP);
      assign tbl[gi] = (SMP_W-1)'(VAL);
   end

   logic [1:0]          quad;
   logic [LUT_AW-1:0]   addr;
   logic [LUT_AW:0]     idx;
   logic signed [SMP_W-1:0] mag;

   always_comb begin
      quad = ph_top[LUT_AW+1 -: 2];
      addr = ph_top[LUT_AW-1:0];
      if (quad[0]) idx = (LUT_AW+1)'(NQ) - {1'b0, addr};
      else         idx = {1'b0, addr};
      mag  = $signed({1'b0, tbl[idx]});
      sine = quad[1] ? -mag : mag;
   end
endmodule

// File: rtl/mtr_env_ramp.sv
module mtr_env_ramp #(
   parameter int ENV_W     = 16,
   parameter int STEP_SLOW = 68,
   parameter int STEP_FAST = 340
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             fast,
   input  logic [ENV_W-1:0] target,
   output logic [ENV_W-1:0] env
);
   localparam logic [ENV_W-1:0] S_SLOW = ENV_W'(STEP_SLOW);
   localparam logic [ENV_W-1:0] S_FAST = ENV_W'(STEP_FAST);

   logic [ENV_W-1:0] step;
   logic [ENV_W-1:0] gap;
   logic [ENV_W-1:0] nxt;

   always_comb begin
      step = fast ? S_FAST : S_SLOW;
      if (env < target) begin
         gap = target - env;
         nxt = (gap > step) ? env + step : target;
      end else begin
         gap = env - target;
         nxt = (gap > step) ? env - step : target;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   env <= '0;
      else if (adv) env <= nxt;
   end
endmodule

// File: rtl/mtr_mix_sat.sv
module mtr_mix_sat #(
   parameter int SMP_W = 16,
   parameter int ENV_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic signed [SMP_W-1:0] sine,
   input  logic [ENV_W-1:0]        env,
   input  logic signed [SMP_W-1:0] audio_in,
   output logic signed [SMP_W-1:0] tone_out,
   output logic signed [SMP_W-1:0] audio_out
);
   localparam int PW = SMP_W + ENV_W;
   localparam logic [SMP_W-1:0] POS_LIM = {1'b0, {(SMP_W-1){1'b1}}};
   localparam logic [SMP_W-1:0] NEG_LIM = {1'b1, {(SMP_W-1){1'b0}}};

   logic signed [PW-1:0]    prod;
   logic                    frac_nz;
   logic signed [SMP_W-1:0] scaled;
   logic [SMP_W:0]          sum;
   logic [SMP_W-1:0]        clamped;

   always_comb begin
      prod    = PW'(sine) * PW'($signed({1'b0, env}));
      frac_nz = |prod[ENV_W-1:0];
      // floor plus one for negative inexact results: truncation toward zero
      scaled  = $signed(prod[PW-1:ENV_W] + SMP_W'(prod[PW-1] & frac_nz));
      sum     = {audio_in[SMP_W-1], audio_in} + {scaled[SMP_W-1], scaled};
      if (sum[SMP_W] != sum[SMP_W-1]) clamped = sum[SMP_W] ? NEG_LIM : POS_LIM;
      else                            clamped = sum[SMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tone_out  <= '0;
         audio_out <= '0;
      end else if (adv) begin
         tone_out  <= scaled;
         audio_out <= $signed(clamped);
      end
   end
endmodule

// File: rtl/mtr_burst_gen.sv
module mtr_burst_gen #(
   parameter int FS_HZ     = 48000,
   parameter int F_LOW_HZ  = 12000,
   parameter int F_HIGH_HZ = 16000,
   parameter int PH_W      = 16,
   parameter int LUT_AW    = 6,
   parameter int SMP_W     = 16,
   parameter int LVL_W     = 8,
   parameter int ENV_FRAC  = 8,
   parameter int RAMP_MS   = 20,
   parameter int FAST_MS   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_valid,
   input  logic                    tone_sel,
   input  logic [LVL_W-1:0]        level_code,
   input  logic                    meter_on,
   input  logic                    fast_ramp,
   input  logic signed [SMP_W-1:0] audio_in,
   output logic signed [SMP_W-1:0] tone_out,
   output logic signed [SMP_W-1:0] audio_out
);
   localparam int ENV_W     = LVL_W + ENV_FRAC;
   localparam int ENV_MAX   = ((1 << LVL_W) - 1) << ENV_FRAC;
   localparam int N_SLOW    = (FS_HZ / 1000) * RAMP_MS;
   localparam int N_FAST    = (FS_HZ / 1000) * FAST_MS;
   localparam int STEP_SLOW = mtr_pkg::ramp_step(ENV_MAX, N_SLOW);
   localparam int STEP_FAST = mtr_pkg::ramp_step(ENV_MAX, N_FAST);
   localparam int INC_LO    = mtr_pkg::phase_inc(F_LOW_HZ, FS_HZ, PH_W);
   localparam int INC_HI    = mtr_pkg::phase_inc(F_HIGH_HZ, FS_HZ, PH_W);

   if (PH_W < LUT_AW + 2) begin : g_bad_ph
      $error("phase width too small for the lookup address");
   end
   if (2 * F_HIGH_HZ >= FS_HZ) begin : g_bad_fs
      $error("tone frequency above half the sample rate");
   end
   if (N_FAST < 1 || N_SLOW < N_FAST) begin : g_bad_ramp
      $error("ramp lengths out of order");
   end
   if (ENV_W > 30 || SMP_W + ENV_W > 62) begin : g_bad_w
      $error("envelope or product width too large");
   end

   logic [PH_W-1:0]         phase_q;
   logic signed [SMP_W-1:0] sine_w;
   logic [ENV_W-1:0]        target_w;
   logic [ENV_W-1:0]        env_q;

   assign target_w = meter_on ? {level_code, {ENV_FRAC{1'b0}}} : '0;

   mtr_phase_acc #(
      .PH_W   (PH_W),
      .INC_LO (INC_LO),
      .INC_HI (INC_HI)
   ) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (smp_valid),
      .sel   (tone_sel),
      .phase (phase_q)
   );

   mtr_sine_lut #(
      .LUT_AW (LUT_AW),
      .SMP_W  (SMP_W)
   ) u_lut (
      .ph_top (phase_q[PH_W-1 -: LUT_AW+2]),
      .sine   (sine_w)
   );

   mtr_env_ramp #(
      .ENV_W     (ENV_W),
      .STEP_SLOW (STEP_SLOW),
      .STEP_FAST (STEP_FAST)
   ) u_env (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (smp_valid),
      .fast   (fast_ramp),
      .target (target_w),
      .env    (env_q)
   );

   mtr_mix_sat #(
      .SMP_W (SMP_W),
      .ENV_W (ENV_W)
   ) u_mix (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (smp_valid),
      .sine      (sine_w),
      .env       (env_q),
      .audio_in  (audio_in),
      .tone_out  (tone_out),
      .audio_out (audio_out)
   );
endmodule

// File: rtl/mtr_burst_chk.sv
module mtr_burst_chk #(
   parameter int SMP_W     = 16,
   parameter int ENV_W     = 16,
   parameter int ENV_MAX   = 65280,
   parameter int STEP_SLOW = 68,
   parameter int STEP_FAST = 340
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    smp_valid,
   input logic                    meter_on,
   input logic                    fast_ramp,
   input logic signed [SMP_W-1:0] audio_in,
   input logic signed [SMP_W-1:0] tone_out,
   input logic signed [SMP_W-1:0] audio_out,
   input logic [ENV_W-1:0]        env
);
   a_r4_env_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      env <= ENV_W'(ENV_MAX));

   a_r5_fast_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> (((env >= $past(env)) ? (env - $past(env)) : ($past(env) - env))
                     <= ENV_W'(STEP_FAST)));

   a_r3_slow_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !fast_ramp) |=> (((env >= $past(env)) ? (env - $past(env)) : ($past(env) - env))
                                     <= ENV_W'(STEP_SLOW)));

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(env) && $stable(tone_out) && $stable(audio_out)));

   a_r6_off_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !meter_on && env == '0) |=> (env == '0));

   a_r8_zero_env_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && env == '0) |=> (tone_out == '0));

   a_r9_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> (!(($past(audio_in) >= 0) && (tone_out >= 0)) || (audio_out >= $past(audio_in))));

   a_r9_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> (!(($past(audio_in) < 0) && (tone_out < 0)) || (audio_out <= $past(audio_in))));
endmodule

bind mtr_burst_gen mtr_burst_chk #(
   .SMP_W     (SMP_W),
   .ENV_W     (ENV_W),
   .ENV_MAX   (ENV_MAX),
   .STEP_SLOW (STEP_SLOW),
   .STEP_FAST (STEP_FAST)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .meter_on  (meter_on),
   .fast_ramp (fast_ramp),
   .audio_in  (audio_in),
   .tone_out  (tone_out),
   .audio_out (audio_out),
   .env       (env_q)
);

// File: tb/test_mtr_burst_gen.sv
module test_mtr_burst_gen;
   localparam int CLK_P = 10;
   localparam int FS    = 48000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic tone_sel = 1'b0;
   logic [7:0] level_code = 8'd0;
   logic meter_on = 1'b0;
   logic fast_ramp = 1'b0;
   logic signed [15:0] audio_in = 16'sd0;
   logic signed [15:0] tone_out;
   logic signed [15:0] audio_out;

   int n_chk = 0;
   int n_err = 0;
   int m_ph  = 0;
   int m_env = 0;

   always #(CLK_P/2) clk = ~clk;

   mtr_burst_gen i_mtr_burst_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .tone_sel   (tone_sel),
      .level_code (level_code),
      .meter_on   (meter_on),
      .fast_ramp  (fast_ramp),
      .audio_in   (audio_in),
      .tone_out   (tone_out),
      .audio_out  (audio_out)
   );

   function automatic int inc_of(input logic sel);
      int f;
      f = sel ? 16000 : 12000;
      return int'(((longint'(f) << 16) + longint'(FS / 2)) / longint'(FS));
   endfunction

   function automatic int exp_sine(input int ph);
      int q, a, i, m;
      q = (ph >> 14) & 3;
      a = (ph >> 8) & 63;
      i = (q & 1) ? 64 - a : a;
      m = int'($floor(32767.0 * $sin(3.14159265358979323846 * real'(i) / 128.0) + 0.5));
      return (q >= 2) ? -m : m;
   endfunction

   function automatic int sat16(input int v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic int aud_pat(input int mode, input int k);
      case (mode)
         1:       return ((k * 997) % 65536) - 32768;
         2:       return 32000;
         3:       return -32000;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      smp_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_ph = 0;
      m_env = 0;
      @(negedge clk);
      check("R10 tone after reset", int'(tone_out), 0);
      check("R10 audio after reset", int'(audio_out), 0);
   endtask

   // One sample: strobe edge, then an idle edge. Starts and ends at a negedge.
   task automatic sample(input string tag, input int aud, output int tone_seen);
      int e_tone, e_out, tgt, stp;
      e_tone = int'((longint'(exp_sine(m_ph)) * longint'(m_env)) / 64'sd65536);
      e_out  = sat16(aud + e_tone);
      smp_valid = 1'b1;
      audio_in  = 16'(aud);
      @(negedge clk);
      smp_valid = 1'b0;
      check({tag, " tone"}, int'(tone_out), e_tone);
      check({tag, " audio"}, int'(audio_out), e_out);
      tone_seen = int'(tone_out);
      m_ph = (m_ph + inc_of(tone_sel)) & 16'hFFFF;
      tgt = meter_on ? int'(level_code) * 256 : 0;
      stp = fast_ramp ? 340 : 68;
      if (m_env < tgt) m_env = (tgt - m_env > stp) ? m_env + stp : tgt;
      else             m_env = (m_env - tgt > stp) ? m_env - stp : tgt;
      @(negedge clk);
      check("R11 tone held without strobe", int'(tone_out), e_tone);
      check("R11 audio held without strobe", int'(audio_out), e_out);
   endtask

   task automatic run(input string tag, input int n, input int mode);
      int ts;
      for (int k = 0; k < n; k++) sample(tag, aud_pat(mode, k), ts);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finished run");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int ts, first, last_nz, hits, kk;
      @(negedge clk);
      check("R10 tone in reset", int'(tone_out), 0);
      check("R10 audio in reset", int'(audio_out), 0);
      do_reset();

      // R3: slow rise at 12 kHz to full scale
      tone_sel = 1'b0; fast_ramp = 1'b0; meter_on = 1'b1; level_code = 8'd255;
      first = -1;
      for (int k = 0; k < 1000; k++) begin
         sample("R3", 0, ts);
         if (ts == 32639 && first < 0) first = k;
      end
      kk = 960;
      while (kk % 4 != 1) kk++;
      check("R3 first full-level peak sample", first, kk);

      // R6: slow fall back to zero
      meter_on = 1'b0;
      last_nz = -1;
      for (int k = 0; k < 1000; k++) begin
         sample("R6", 0, ts);
         if (ts != 0) last_nz = k;
      end
      check("R6 last nonzero tone sample", last_nz, 959);

      // R10: reset mid-state
      do_reset();

      // R5: fast rise
      fast_ramp = 1'b1; meter_on = 1'b1; level_code = 8'd255;
      first = -1;
      for (int k = 0; k < 200; k++) begin
         sample("R5", 0, ts);
         if (ts == 32639 && first < 0) first = k;
      end
      check("R5 first full-level peak sample", first, 193);

      // R2: waveform at full level, phase now 0 (200 samples of 12 kHz)
      sample("R2", 0, ts); check("R2 zero crossing", ts, 0);
      sample("R2", 0, ts); check("R2 positive peak", ts, 32639);
      sample("R2", 0, ts); check("R2 zero crossing", ts, 0);
      sample("R2", 0, ts); check("R2 negative peak", ts, -32639);

      // R1: switch to 16 kHz and back, phase continuous
      tone_sel = 1'b1;
      run("R1", 300, 0);
      tone_sel = 1'b0;
      run("R1", 100, 0);

      // R8: scaling with sweeping audio at 16 kHz
      do_reset();
      tone_sel = 1'b1; fast_ramp = 1'b0; meter_on = 1'b1; level_code = 8'd128;
      run("R8", 400, 1);

      // R7: target moves during ramps
      do_reset();
      tone_sel = 1'b0; fast_ramp = 1'b0; meter_on = 1'b1; level_code = 8'd255;
      run("R7", 300, 0);
      level_code = 8'd100; run("R7", 200, 0);
      level_code = 8'd50;  run("R7", 300, 0);
      meter_on = 1'b0;     run("R7", 100, 0);
      meter_on = 1'b1; level_code = 8'd200; fast_ramp = 1'b1; run("R7", 100, 0);
      fast_ramp = 1'b0; level_code = 8'd199; run("R7", 50, 0);

      // R4: level code sweep, fast ramp, peak read at sample 197 of each batch
      do_reset();
      tone_sel = 1'b0; fast_ramp = 1'b1; meter_on = 1'b1;
      for (int c = 0; c < 256; c += 17) begin
         level_code = 8'(c);
         for (int k = 0; k < 200; k++) begin
            sample("R4", 0, ts);
            if (k == 197) check("R4 peak for level code", ts, (32767 * c * 256) / 65536);
         end
      end

      // R9: saturation against full-level tone
      do_reset();
      tone_sel = 1'b0; fast_ramp = 1'b1; meter_on = 1'b1; level_code = 8'd255;
      run("R9", 200, 0);
      hits = 0;
      for (int k = 0; k < 200; k++) begin
         sample("R9", aud_pat(2, k), ts);
         if (audio_out == 16'sd32767) hits++;
      end
      check("R9 positive clamp reached", int'(hits > 0), 1);
      hits = 0;
      for (int k = 0; k < 200; k++) begin
         sample("R9", aud_pat(3, k), ts);
         if (audio_out == -16'sd32768) hits++;
      end
      check("R9 negative clamp reached", int'(hits > 0), 1);
      tone_sel = 1'b1;
      run("R9", 400, 1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule